// File: doc/BRIEF.md
# Low-Power Mode and Wake-Up Controller

This block is the system-control unit of a small microcontroller. Software programs it through two 8-bit registers on a simple register bus. From those writes the block moves the core between its operating modes: running on the fast or the slow clock, CPU-halted idle, a sleep in which the peripheral clocks are also stopped, and a full stop. It drives the enables of both oscillators, selects the system clock, and gates the clocks of the CPU, the watchdog and the peripherals.

In stop mode both oscillators are shut off. The port pads are either held or floated, as programmed. A wake pin ends the stop. The pin can be read for a falling edge or for a high level. The block then turns on the oscillator for the chosen return clock and counts a programmable warm-up interval. Only after that count does it let the CPU clock run again. Software errors are caught in hardware: a write that would leave the core with no running clock forces a system reset, and a write that asks for both halt modes at once is rejected.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset, register 0 reads 0x00 and register 1 reads 0x80. The CPU, watchdog and peripheral clock enables and the fast-oscillator enable are high, and the slow-oscillator enable is low. Unimplemented bits (register 0 bits 1:0, register 1 bits 3, 1, 0) always read 0.
- R2: In run, a write to register 0 with bit 7 set (and the release is not already satisfied, see R4) enters stop. From the next cycle, all clock enables and both oscillator enables are low. Bit 7 reads back as 0 once the CPU runs again.
- R3: With register 0 bit 6 = 0 (edge release), stop ends only on a falling edge of the wake pin, meaning the pin is high in one cycle and low in the next. A rising edge or a steady level does not end stop.
- R4: With register 0 bit 6 = 1 (level release), stop is held while the wake pin is low and ends when it is high. If the pin is already high in the cycle of the stop request, stop is not entered and bit 7 reads 0.
- R5: On release, the return clock is the slow clock when bit 6 = 0 and bit 5 = 1. In that case register 1 bits 6 and 5 become 1. Otherwise the return clock is the fast clock, and register 1 bit 7 becomes 1 and bit 5 becomes 0. Level release always returns to the fast clock.
- R6: After the release cycle, the CPU clock enable stays low for exactly N cycles. It then rises in the same cycle as a one-cycle mode-changed strobe. For register 0 bits 3:2 = 00/01/10/11, N is 3·2^FH, 2^FH, 3·2^FL and 2^FL on the fast clock, and 3·2^SH, 2^SH, 3·2^SL and 2^SL on the slow clock.
- R7: During stop and warm-up, the port high-impedance output is high when register 0 bit 4 = 0 and low when it is 1.
- R8: A register 1 write with bit 4 set halts the CPU and watchdog but keeps the peripherals clocked. A write with bit 2 set halts all three. A wake interrupt returns to run, clears the halt bit and pulses the mode-changed strobe.
- R9: A register 1 write with bits 4 and 2 both set sets neither halt bit, keeps the core running and pulses the halt-error output for one cycle.
- R10: A register 1 write that clears both oscillator enables, or that clears the enable of the currently selected clock (bit 5: 0 = fast, 1 = slow), pulses the reset-request output for one cycle and returns both registers to their reset values.
- R11: Register writes are ignored in every state except run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select (0 = mode/stop register, 1 = clock/halt register) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| wake_pin | input | 1 | Stop-release pin, synchronous to clk |
| wake_irq | input | 1 | Interrupt wake from idle or sleep |
| hosc_en | output | 1 | Fast oscillator enable |
| losc_en | output | 1 | Slow oscillator enable |
| clk_sel_low | output | 1 | System clock select, 1 = slow clock |
| cpu_clk_en | output | 1 | CPU clock enable |
| wdt_clk_en | output | 1 | Watchdog clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| port_hiz | output | 1 | Float port outputs |
| rst_req | output | 1 | One-cycle forced-reset request |
| halt_err | output | 1 | One-cycle illegal-halt-write flag |
| mode_chg | output | 1 | One-cycle strobe on return to run |

## Verification
The bench measures the warm-up length in several ways: on both clocks, for the long and short shift, and for the triple and single multiplier. A counter that is off by one, or that picks the wrong clock's table, therefore shows up as a wrong cycle count. It drives a rising edge during an edge-mode stop and a high pin at a level-mode stop request. A detector that reacts to any change would wake early, and one that ignores the entry rule would hang in stop. It sets the return-to-slow bit together with level release to catch a design that obeys that bit. It also tries every forced-reset condition, the illegal double halt, and a write during idle, which a design without run-only writes would apply.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [2:0] {
        ST_RUN  = 3'd0,
        ST_IDLE = 3'd1,
        ST_TGH  = 3'd2,
        ST_STOP = 3'd3,
        ST_WARM = 3'd4
    } lpm_state_e;

    // register 0 implemented fields, bit 7 down to bit 2
    typedef struct packed {
        logic       stop;
        logic       rel_lvl;
        logic       ret_slow;
        logic       out_keep;
        logic [1:0] wsel;
    } cfg_mode_t;

    // register 1 implemented fields: bits 7,6,5,4 and 2
    typedef struct packed {
        logic hi_en;
        logic lo_en;
        logic lo_sel;
        logic cpu_halt;
        logic per_halt;
    } cfg_clk_t;

    typedef struct packed {
        lpm_state_e st;
        cfg_mode_t  c1;
        cfg_clk_t   c2;
        logic       rst_p;
        logic       err_p;
        logic       chg_p;
    } lpm_regs_t;

endpackage

// File: rtl/lpm_wake_det.sv
module lpm_wake_det (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic lvl_mode,
    output logic release_o
);
    logic pin_d, pin_q;

    always_comb begin
        pin_d     = pin;
        release_o = lvl_mode ? pin : (pin_q & ~pin);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= pin_d;
    end
endmodule

// File: rtl/lpm_warm_ctr.sv
module lpm_warm_ctr #(
    parameter int CW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)              cnt_d = load_val;
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
        done = (cnt_q == CW'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int FAST_HI = 16,
    parameter int FAST_LO = 14,
    parameter int SLOW_HI = 13,
    parameter int SLOW_LO = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic       bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       wake_pin,
    input  logic       wake_irq,
    output logic       hosc_en,
    output logic       losc_en,
    output logic       clk_sel_low,
    output logic       cpu_clk_en,
    output logic       wdt_clk_en,
    output logic       periph_clk_en,
    output logic       port_hiz,
    output logic       rst_req,
    output logic       halt_err,
    output logic       mode_chg
);
    localparam int CW = FAST_HI + 2;
    localparam lpm_regs_t S_RST = {ST_RUN, 6'b000000, 5'b10000, 3'b000};

    lpm_regs_t     s_d, s_q;
    logic          wake_rel;
    logic          ld;
    logic [CW-1:0] ld_val;
    logic          warm_done;
    logic          bad_osc;
    logic          unused_wbits;

    assign unused_wbits = ^{bus_wdata[3], bus_wdata[1:0]};

    function automatic logic [CW-1:0] warm_len(input logic slow, input logic [1:0] sel);
        int sh;
        if (slow) sh = sel[1] ? SLOW_LO : SLOW_HI;
        else      sh = sel[1] ? FAST_LO : FAST_HI;
        return sel[0] ? (CW'(1) << sh) : (CW'(3) << sh);
    endfunction

    lpm_wake_det u_wake (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin       (wake_pin),
        .lvl_mode  (s_q.c1.rel_lvl),
        .release_o (wake_rel)
    );

    lpm_warm_ctr #(.CW(CW)) u_warm (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .load_val (ld_val),
        .done     (warm_done)
    );

    always_comb begin
        s_d       = s_q;
        s_d.rst_p = 1'b0;
        s_d.err_p = 1'b0;
        s_d.chg_p = 1'b0;
        ld        = 1'b0;
        ld_val    = warm_len(1'b0, s_q.c1.wsel);
        bad_osc   = (!bus_wdata[7] && !bus_wdata[6]) ||
                    (!bus_wdata[7] && !s_q.c2.lo_sel) ||
                    (!bus_wdata[6] &&  s_q.c2.lo_sel);
        case (s_q.st)
            ST_RUN: begin
                if (bus_wr && !bus_addr) begin
                    s_d.c1 = cfg_mode_t'(bus_wdata[7:2]);
                    if (bus_wdata[7]) begin
                        if (bus_wdata[6] && wake_pin) s_d.c1.stop = 1'b0;
                        else                          s_d.st      = ST_STOP;
                    end
                end else if (bus_wr && bus_addr) begin
                    if (bad_osc) begin
                        s_d       = S_RST;
                        s_d.rst_p = 1'b1;
                    end else if (bus_wdata[4] && bus_wdata[2]) begin
                        s_d.c2    = {bus_wdata[7:5], 2'b00};
                        s_d.err_p = 1'b1;
                    end else begin
                        s_d.c2 = {bus_wdata[7:4], bus_wdata[2]};
                        if (bus_wdata[4])      s_d.st = ST_IDLE;
                        else if (bus_wdata[2]) s_d.st = ST_TGH;
                    end
                end
            end
            ST_IDLE, ST_TGH: begin
                if (wake_irq) begin
                    s_d.st          = ST_RUN;
                    s_d.c2.cpu_halt = 1'b0;
                    s_d.c2.per_halt = 1'b0;
                    s_d.chg_p       = 1'b1;
                end
            end
            ST_STOP: begin
                if (wake_rel) begin
                    s_d.st = ST_WARM;
                    ld     = 1'b1;
                    if (!s_q.c1.rel_lvl && s_q.c1.ret_slow) begin
                        s_d.c2.lo_en  = 1'b1;
                        s_d.c2.lo_sel = 1'b1;
                        ld_val        = warm_len(1'b1, s_q.c1.wsel);
                    end else begin
                        s_d.c2.hi_en  = 1'b1;
                        s_d.c2.lo_sel = 1'b0;
                    end
                end
            end
            ST_WARM: begin
                if (warm_done) begin
                    s_d.st      = ST_RUN;
                    s_d.c1.stop = 1'b0;
                    s_d.chg_p   = 1'b1;
                end
            end
            default: s_d = S_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= S_RST;
        else        s_q <= s_d;
    end

    always_comb begin
        bus_rdata     = bus_addr ? {s_q.c2.hi_en, s_q.c2.lo_en, s_q.c2.lo_sel, s_q.c2.cpu_halt,
                                    1'b0, s_q.c2.per_halt, 2'b00}
                                 : {s_q.c1, 2'b00};
        hosc_en       = s_q.c2.hi_en & (s_q.st != ST_STOP);
        losc_en       = s_q.c2.lo_en & (s_q.st != ST_STOP);
        clk_sel_low   = s_q.c2.lo_sel;
        cpu_clk_en    = (s_q.st == ST_RUN);
        wdt_clk_en    = (s_q.st == ST_RUN);
        periph_clk_en = (s_q.st == ST_RUN) || (s_q.st == ST_IDLE);
        port_hiz      = ((s_q.st == ST_STOP) || (s_q.st == ST_WARM)) && !s_q.c1.out_keep;
        rst_req       = s_q.rst_p;
        halt_err      = s_q.err_p;
        mode_chg      = s_q.chg_p;
    end
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic cpu_clk_en,
    input logic periph_clk_en,
    input logic port_hiz,
    input logic rst_req,
    input logic halt_err,
    input logic mode_chg
);
    assert_err_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halt_err |=> !halt_err);

    assert_rst_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    assert_chg_with_cpu_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |-> cpu_clk_en);

    assert_cpu_rise_strobed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_clk_en) |-> mode_chg);

    assert_float_clocks_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        port_hiz |-> (!cpu_clk_en && !periph_clk_en));

    assert_chg_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> !mode_chg);
endmodule

bind lpm_ctrl lpm_ctrl_chk u_chk (.*);

// File: tb/lpm_ctrl_test.sv
module lpm_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       wake_pin = 1'b0;
    logic       wake_irq = 1'b0;
    logic hosc_en, losc_en, clk_sel_low, cpu_clk_en, wdt_clk_en, periph_clk_en;
    logic port_hiz, rst_req, halt_err, mode_chg;

    int n_chk = 0;
    int n_bad = 0;
    int wd = 0;

    always #10 clk = ~clk;

    lpm_ctrl #(.FAST_HI(6), .FAST_LO(4), .SLOW_HI(5), .SLOW_LO(2)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wake_pin(wake_pin),
        .wake_irq(wake_irq), .hosc_en(hosc_en), .losc_en(losc_en),
        .clk_sel_low(clk_sel_low), .cpu_clk_en(cpu_clk_en), .wdt_clk_en(wdt_clk_en),
        .periph_clk_en(periph_clk_en), .port_hiz(port_hiz), .rst_req(rst_req),
        .halt_err(halt_err), .mode_chg(mode_chg)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int       m_st = 0;
    int       m_cnt = 0;
    bit [7:0] m_c1 = 8'h00;
    bit [7:0] m_c2 = 8'h80;
    bit       m_prev = 0, m_rst = 0, m_err = 0, m_chg = 0, m_rel = 0;

    function automatic int wlen(input bit slow, input bit [1:0] sel);
        int sh;
        if (slow) sh = sel[1] ? 2 : 5;
        else      sh = sel[1] ? 4 : 6;
        return (sel[0] ? 1 : 3) * (1 << sh);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_c1 = 8'h00; m_c2 = 8'h80; m_cnt = 0;
            m_prev = 0; m_rst = 0; m_err = 0; m_chg = 0;
        end else begin
            m_rel  = m_c1[6] ? wake_pin : (m_prev && !wake_pin);
            m_prev = wake_pin;
            m_rst = 0; m_err = 0; m_chg = 0;
            case (m_st)
                0: if (bus_wr && !bus_addr) begin
                       m_c1 = bus_wdata & 8'hFC;
                       if (bus_wdata[7]) begin
                           if (bus_wdata[6] && wake_pin) m_c1[7] = 0;
                           else m_st = 3;
                       end
                   end else if (bus_wr) begin
                       if ((!bus_wdata[7] && !bus_wdata[6]) || (!bus_wdata[7] && !m_c2[5]) ||
                           (!bus_wdata[6] && m_c2[5])) begin
                           m_c1 = 8'h00; m_c2 = 8'h80; m_rst = 1;
                       end else if (bus_wdata[4] && bus_wdata[2]) begin
                           m_c2 = bus_wdata & 8'hE0; m_err = 1;
                       end else begin
                           m_c2 = bus_wdata & 8'hF4;
                           if (bus_wdata[4]) m_st = 1;
                           else if (bus_wdata[2]) m_st = 2;
                       end
                   end
                1, 2: if (wake_irq) begin m_st = 0; m_c2 = m_c2 & 8'hE0; m_chg = 1; end
                3: if (m_rel) begin
                       m_st = 4;
                       if (!m_c1[6] && m_c1[5]) begin
                           m_c2[6] = 1; m_c2[5] = 1; m_cnt = wlen(1, m_c1[3:2]);
                       end else begin
                           m_c2[7] = 1; m_c2[5] = 0; m_cnt = wlen(0, m_c1[3:2]);
                       end
                   end
                default: if (m_cnt == 1) begin m_st = 0; m_c1[7] = 0; m_chg = 1; end
                         else m_cnt--;
            endcase
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            check("R6 cpu_clk_en", cpu_clk_en, m_st == 0);
            check("R8 wdt_clk_en", wdt_clk_en, m_st == 0);
            check("R8 periph_clk_en", periph_clk_en, m_st <= 1);
            check("R5 hosc_en", hosc_en, m_c2[7] && m_st != 3);
            check("R5 losc_en", losc_en, m_c2[6] && m_st != 3);
            check("R5 clk_sel_low", clk_sel_low, m_c2[5]);
            check("R7 port_hiz", port_hiz, (m_st == 3 || m_st == 4) && !m_c1[4]);
            check("R10 rst_req", rst_req, m_rst);
            check("R9 halt_err", halt_err, m_err);
            check("R6 mode_chg", mode_chg, m_chg);
            check("R1 bus_rdata", bus_rdata, bus_addr ? m_c2 : m_c1);
        end
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected<150000", wd);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wr(input bit a, input bit [7:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        step(1);
        bus_wr = 0;
    endtask

    task automatic wait_run(output int k);
        k = 0;
        while (!cpu_clk_en && k < 1000) begin step(1); k++; end
    endtask

    initial begin
        int k;
        step(3);
        rst_n = 1;
        step(1);
        // R1 reset state
        bus_addr = 0; #1 check("R1 reg0 reset", bus_rdata, 8'h00);
        bus_addr = 1; #1 check("R1 reg1 reset", bus_rdata, 8'h80);
        check("R1 cpu on", cpu_clk_en, 1);
        check("R1 losc off", losc_en, 0);
        step(1);

        // R2/R3/R6: edge release, fast clock, code 00 -> 192
        wake_pin = 1; step(1);
        wr(0, 8'h80);
        check("R2 cpu off in stop", cpu_clk_en, 0);
        check("R2 hosc off in stop", hosc_en, 0);
        check("R7 float in stop", port_hiz, 1);
        step(3);
        check("R3 steady high keeps stop", cpu_clk_en, 0);
        wake_pin = 0; step(1);
        check("R5 hosc on in warm", hosc_en, 1);
        wait_run(k);
        check("R6 warm fast code00", k, 192);
        check("R6 strobe", mode_chg, 1);
        bus_addr = 0; #1 check("R2 stop bit cleared", bus_rdata, 8'h00);
        step(1);
        check("R6 strobe one cycle", mode_chg, 0);

        // R3 rising edge ignored; R5 slow return; code 11 slow -> 4
        wr(0, 8'hAC);
        wake_pin = 1; step(3);
        check("R3 rising edge ignored", cpu_clk_en, 0);
        wake_pin = 0; step(1);
        wait_run(k);
        check("R6 warm slow code11", k, 4);
        check("R5 slow selected", clk_sel_low, 1);
        check("R5 slow osc on", losc_en, 1);
        wr(1, 8'hC0);
        check("R5 back to fast", clk_sel_low, 0);

        // R4 pin high at level-mode request: no stop
        wake_pin = 1; step(1);
        wr(0, 8'hC0);
        check("R4 no stop when high", cpu_clk_en, 1);
        bus_addr = 0; #1 check("R4 stop bit reads 0", bus_rdata, 8'h40);

        // R4 level hold, R5 level ignores return-slow, code 10 fast -> 48
        wake_pin = 0; step(1);
        wr(0, 8'hE8);
        step(5);
        check("R4 held while low", cpu_clk_en, 0);
        wake_pin = 1; step(1);
        wait_run(k);
        check("R6 warm fast code10", k, 48);
        check("R5 level returns fast", clk_sel_low, 0);

        // R7 output hold, code 11 fast -> 16
        wr(0, 8'h9C);
        check("R7 hold keeps ports", port_hiz, 0);
        check("R2 cpu off", cpu_clk_en, 0);
        wake_pin = 0; step(1);
        wait_run(k);
        check("R6 warm fast code11", k, 16);

        // R8 idle1, R11 write ignored
        wr(1, 8'hD0);
        check("R8 idle cpu off", cpu_clk_en, 0);
        check("R8 idle periph on", periph_clk_en, 1);
        wr(0, 8'h80);
        check("R11 write ignored in idle", cpu_clk_en, 0);
        bus_addr = 0; #1 check("R11 reg0 unchanged", bus_rdata, 8'h1C);
        wake_irq = 1; step(1); wake_irq = 0;
        check("R8 idle exit", cpu_clk_en, 1);
        check("R8 exit strobe", mode_chg, 1);
        bus_addr = 1; #1 check("R8 halt bit cleared", bus_rdata, 8'hC0);

        // R8 idle0
        wr(1, 8'hC4);
        check("R8 sleep periph off", periph_clk_en, 0);
        check("R8 sleep cpu off", cpu_clk_en, 0);
        step(2);
        wake_irq = 1; step(1); wake_irq = 0;
        bus_addr = 1; #1 check("R8 periph halt cleared", bus_rdata, 8'hC0);

        // R9 illegal double halt
        wr(1, 8'hD4);
        check("R9 error pulse", halt_err, 1);
        check("R9 core runs", cpu_clk_en, 1);
        bus_addr = 1; #1 check("R9 no halt bits", bus_rdata, 8'hC0);
        step(1);
        check("R9 pulse ends", halt_err, 0);

        // R10 forced resets
        wr(1, 8'h00);
        check("R10 both off", rst_req, 1);
        bus_addr = 1; #1 check("R10 reg1 reset", bus_rdata, 8'h80);
        bus_addr = 0; #1 check("R10 reg0 reset", bus_rdata, 8'h00);
        step(1);
        wr(1, 8'h40);
        check("R10 fast off while fast", rst_req, 1);
        step(1);
        wr(1, 8'hC0);
        wr(1, 8'hE0);
        check("R10 legal switch", rst_req, 0);
        wr(1, 8'hA0);
        check("R10 slow off while slow", rst_req, 1);
        step(3);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule